// File: doc/BRIEF.md
# Presettable Dual-Enable Binary Counter

This block is a synchronous binary up-counter, four bits wide by default, with a small fixed set of controls. An active-low clear acts at once, with or without a running clock. An active-low load copies a parallel preset word into the count on the next rising edge. Counting happens only when two separate enables are both high. A carry output goes high when the count is at its all-ones value, so a following stage can extend the count.

One of the two enables is the gate enable. It only allows counting. The other is the chain enable. It also qualifies the carry output, so that a stage further down a chain sees a carry only when the upstream stage is allowed to pass one on. The carry output is combinational. It follows the count and the chain enable between clock edges.

Top module: `sync_preset_counter`

## Requirements
- R1: While `clr_n` is low, `count_q` is zero within the same time step, without any clock edge. This holds when the clock is stopped.
- R2: Clear overrides all other controls. While `clr_n` is low, rising edges leave `count_q` at zero, whatever `load_n`, the enables and `preset_val` are.
- R3: With `clr_n` high and `load_n` low at a rising edge, `count_q` takes the value of `preset_val` after that edge. This holds for every combination of the two enables.
- R4: With `clr_n` and `load_n` high and both `gate_en` and `chain_en` high at a rising edge, `count_q` increases by one after that edge.
- R5: An increment from the all-ones value (15 at the default width) wraps `count_q` to zero.
- R6: With `clr_n` and `load_n` high and at least one of `gate_en` or `chain_en` low at a rising edge, `count_q` keeps its value.
- R7: `carry_out` is high exactly when `count_q` is all ones and `chain_en` is high. It does not depend on `gate_en`, and it changes with its inputs without waiting for a clock edge.
- R8: On the first rising edge after `clr_n` returns high, load and count act normally. No extra recovery cycle is inserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous preset load, active low |
| gate_en | input | 1 | Count enable that only gates counting |
| chain_en | input | 1 | Count enable that also qualifies the carry output |
| preset_val | input | WIDTH (4) | Parallel preset value |
| count_q | output | WIDTH (4) | Current count |
| carry_out | output | 1 | High when the count is all ones and `chain_en` is high |

## Verification
Load, increment, hold and wrap each take effect on the first rising edge after the inputs are driven. The bench drives inputs on the falling edge, pushes the expected count and carry into a queue, and the monitor pops and compares them 2 ns after the next rising edge. Clear and carry need no edge, so they are checked directly a few nanoseconds after their input changes. These checks are made between edges or with the clock held stopped, so no edge can be mistaken for the cause. Clear release is checked on the very first edge after release, which confirms that no extra recovery cycle is inserted.

// File: rtl/preset_counter_pkg.sv
package preset_counter_pkg;

  // Action the counter takes at the next rising edge
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_LOAD = 2'b01,
    OP_INCR = 2'b10
  } cnt_op_e;

endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
  import preset_counter_pkg::*;
(
  input  logic    load_n,
  input  logic    gate_en,
  input  logic    chain_en,
  output cnt_op_e op
);

  // Load beats counting; counting needs both enables
  always_comb begin
    op = OP_HOLD;
    if (!load_n) begin
      op = OP_LOAD;
    end else if (gate_en && chain_en) begin
      op = OP_INCR;
    end
  end

endmodule

// File: rtl/cnt_next_state.sv
module cnt_next_state
  import preset_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] cur_cnt,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] nxt_cnt,
  output logic             upd_en
);

  logic [WIDTH-1:0] toggle;
  logic [WIDTH-1:0] incr_val;

  // Bit i toggles when every lower bit is one
  assign toggle[0] = 1'b1;
  generate
    for (genvar i = 1; i < WIDTH; i++) begin : g_toggle
      assign toggle[i] = toggle[i-1] & cur_cnt[i-1];
    end
  endgenerate

  assign incr_val = cur_cnt ^ toggle;

  always_comb begin
    nxt_cnt = cur_cnt;
    upd_en  = 1'b0;
    unique case (op)
      OP_LOAD: begin
        nxt_cnt = preset_val;
        upd_en  = 1'b1;
      end
      OP_INCR: begin
        nxt_cnt = incr_val;
        upd_en  = 1'b1;
      end
      default: begin
        nxt_cnt = cur_cnt;
        upd_en  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             upd_en,
  input  logic [WIDTH-1:0] nxt_cnt,
  output logic [WIDTH-1:0] cnt_q
);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      cnt_q <= '0;
    end else if (upd_en) begin
      cnt_q <= nxt_cnt;
    end
  end

endmodule

// File: rtl/cnt_carry_gen.sv
module cnt_carry_gen #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt,
  input  logic             chain_en,
  output logic             carry
);

  logic [WIDTH-1:0] ones;

  assign ones[0] = cnt[0];
  generate
    for (genvar i = 1; i < WIDTH; i++) begin : g_ones
      assign ones[i] = ones[i-1] & cnt[i];
    end
  endgenerate

  assign carry = ones[WIDTH-1] & chain_en;

endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
  import preset_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             gate_en,
  input  logic             chain_en,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] count_q,
  output logic             carry_out
);

  cnt_op_e          op;
  logic [WIDTH-1:0] nxt_cnt;
  logic             upd_en;

  cnt_op_decode u_decode (
    .load_n   (load_n),
    .gate_en  (gate_en),
    .chain_en (chain_en),
    .op       (op)
  );

  cnt_next_state #(.WIDTH(WIDTH)) u_next (
    .op         (op),
    .cur_cnt    (count_q),
    .preset_val (preset_val),
    .nxt_cnt    (nxt_cnt),
    .upd_en     (upd_en)
  );

  cnt_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk     (clk),
    .clr_n   (clr_n),
    .upd_en  (upd_en),
    .nxt_cnt (nxt_cnt),
    .cnt_q   (count_q)
  );

  cnt_carry_gen #(.WIDTH(WIDTH)) u_carry (
    .cnt      (count_q),
    .chain_en (chain_en),
    .carry    (carry_out)
  );

endmodule

// File: rtl/preset_counter_chk.sv
module preset_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             gate_en,
  input logic             chain_en,
  input logic [WIDTH-1:0] preset_val,
  input logic [WIDTH-1:0] count_q,
  input logic             carry_out
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  // R1: clear holds the count at zero
  always @(negedge clk) begin
    if (!clr_n) begin
      a_r1_clear_zero: assert (count_q == '0)
        else $error("count not zero under clear");
    end
  end

  // R3: load takes the preset on the next edge
  a_r3_load_preset: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> count_q == $past(preset_val));

  // R4: both enables advance the count by one
  a_r4_increment: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && gate_en && chain_en) |=> count_q == $past(count_q) + WIDTH'(1));

  // R6: a low enable holds the count
  a_r6_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(gate_en && chain_en)) |=> $stable(count_q));

  // R7: carry at all ones with chain enable
  a_r7_carry_high: assert property (@(posedge clk) disable iff (!clr_n)
    (chain_en && count_q == ALL_ONES) |-> carry_out);

  // R7: no carry without chain enable or below all ones
  a_r7_carry_low: assert property (@(posedge clk) disable iff (!clr_n)
    (!chain_en || count_q != ALL_ONES) |-> !carry_out);

endmodule

bind sync_preset_counter preset_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .clr_n      (clr_n),
  .load_n     (load_n),
  .gate_en    (gate_en),
  .chain_en   (chain_en),
  .preset_val (preset_val),
  .count_q    (count_q),
  .carry_out  (carry_out)
);

// File: tb/sync_preset_counter_tb.sv
module sync_preset_counter_tb;

  localparam int W = 4;

  typedef struct {
    logic [W-1:0] cnt;
    logic         cy;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         clk_run = 1'b1;
  logic         clr_n;
  logic         load_n;
  logic         gate_en;
  logic         chain_en;
  logic [W-1:0] preset_val;
  logic [W-1:0] count_q;
  logic         carry_out;

  int           n_vec  = 0;
  int           n_fail = 0;
  logic [W-1:0] model_q;
  exp_t         sb_q[$];
  bit           done = 1'b0;

  // 50 MHz: 20 ns period
  always #10 if (clk_run) clk = ~clk;

  sync_preset_counter #(.WIDTH(W)) u_dut (
    .clk        (clk),
    .clr_n      (clr_n),
    .load_n     (load_n),
    .gate_en    (gate_en),
    .chain_en   (chain_en),
    .preset_val (preset_val),
    .count_q    (count_q),
    .carry_out  (carry_out)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: drive on the falling edge, push expected result of the next rising edge
  task automatic step(input logic ld_n, input logic ge, input logic ce, input logic [W-1:0] pv);
    exp_t e;
    @(negedge clk);
    load_n = ld_n; gate_en = ge; chain_en = ce; preset_val = pv;
    if (!ld_n) begin
      model_q = pv;
      e.tag = "R3";
    end else if (ge && ce) begin
      e.tag = (model_q == '1) ? "R5" : "R4";
      model_q = model_q + W'(1);
    end else begin
      e.tag = "R6";
    end
    e.cnt = model_q;
    e.cy  = (model_q == '1) && ce;
    sb_q.push_back(e);
  endtask

  task automatic drain();
    wait (sb_q.size() == 0);
    #1;
  endtask

  // Monitor: compare 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, count_q, e.cnt);
        check({e.tag, "/R7"}, W'(carry_out), W'(e.cy));
      end
    end
  end

  // Watchdog
  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    clr_n = 1'b0; load_n = 1'b1; gate_en = 1'b0; chain_en = 1'b0; preset_val = '0;
    #5;
    check("R1 reset", count_q, '0);
    check("R1 reset carry", W'(carry_out), '0);

    @(negedge clk);
    clr_n = 1'b1;
    model_q = '0;

    // Directed increments through the wrap
    for (int i = 0; i < 18; i++) step(1'b1, 1'b1, 1'b1, W'(i));
    // Loads under every enable combination
    for (int i = 0; i < 4; i++) step(1'b0, i[0], i[1], W'(3 * i + 2));
    // Holds with one or both enables low
    step(1'b1, 1'b0, 1'b1, '0);
    step(1'b1, 1'b1, 1'b0, '1);
    step(1'b1, 1'b0, 1'b0, 4'd9);
    // Hold at all ones: carry follows chain enable only
    step(1'b0, 1'b0, 1'b0, '1);
    step(1'b1, 1'b1, 1'b0, '0);
    step(1'b1, 1'b0, 1'b1, '0);
    drain();

    // Carry changes between edges without a clock edge
    @(negedge clk);
    load_n = 1'b1; gate_en = 1'b0; chain_en = 1'b1;
    #2 check("R7 carry chain on", W'(carry_out), W'(1));
    gate_en = 1'b1;
    #2 check("R7 carry ignores gate", W'(carry_out), W'(1));
    chain_en = 1'b0;
    #2 check("R7 carry chain off", W'(carry_out), '0);
    gate_en = 1'b0;

    // Random stimulus
    for (int i = 0; i < 300; i++) begin
      step(($urandom_range(0, 3) != 0), $urandom_range(0, 1) != 0,
           $urandom_range(0, 1) != 0, W'($urandom_range(0, (1 << W) - 1)));
    end
    step(1'b0, 1'b0, 1'b0, 4'd9);
    drain();

    // Clear with the clock stopped
    @(negedge clk);
    clk_run = 1'b0;
    #3;
    check("R1 pre-clear count", count_q, 4'd9);
    clr_n = 1'b0;
    #3 check("R1 clear stopped clock", count_q, '0);
    #50 check("R1 clear stays", count_q, '0);

    // Clear dominates load and enables
    load_n = 1'b0; gate_en = 1'b1; chain_en = 1'b1; preset_val = 4'd7;
    clk_run = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #2 check("R2 clear dominates", count_q, '0);
    end

    // First edge after release acts
    @(negedge clk);
    clr_n = 1'b1;
    model_q = 4'd7;
    begin
      exp_t e;
      e.cnt = 4'd7; e.cy = 1'b0; e.tag = "R8";
      sb_q.push_back(e);
    end
    step(1'b1, 1'b1, 1'b1, '0);
    step(1'b1, 1'b1, 1'b1, '0);
    drain();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule